// File: doc/BRIEF.md
# SD/MMC Host Status and Dual Interrupt Unit

This block is the status and interrupt section of an SD/MMC host controller. The command path and the data path report events through one-cycle set pulses. Each pulse sets a sticky status bit, and that bit stays set until software clears it. The FIFO and activity flags are not stored as events. They follow the data path's live state and are sampled once per clock. Together, the sticky bits and the live bits form a 22-bit status word.

Software reaches the block through a simple register port. Writes are single-cycle and reads are combinational. From this port, software can:
- read the status word;
- clear sticky bits with a write-one-to-clear register;
- program two independent 32-bit mask registers, each driving its own level interrupt line;
- keep an 8-bit power setting and an 8-bit clock setting;
- read an eight-word peripheral identification window at the top of the 4 KiB register space.

Top module: `sdhc_stat_irq`

## Requirements
- R1: After reset, the status word, both masks, the power register and the clock register all read zero, and both interrupt lines are low.
- R2: The power register (0x000) and the clock register (0x004) keep only bits 7:0 of a write. Bits 31:8 read as zero.
- R3: A one-cycle set pulse on `evt_set[b]` makes status bit b (for b from 0 to 10) read as 1 from the next clock on. The bit stays 1 until it is cleared.
- R4: Status bit 9 is reserved and always reads 0, even when its set pulse is driven.
- R5: A write to the clear register (0x038) clears each status bit in 10:0 whose written bit is 1. Written bits 31:11 have no effect, so the live bits are unchanged.
- R6: If a set pulse and a clear write hit the same sticky bit in the same cycle, the set wins and the bit reads 1.
- R7: Status bits 21:11 equal `live_flags[10:0]` as sampled at the previous clock edge. The order from bit 11 up is: command active, TX active, RX active, TX half-empty, RX half-full, TX full, RX full, TX empty, RX empty, TX data available, RX data available.
- R8: `irq_out[i]` is high exactly while the status word ANDed with mask i is nonzero. Mask 0 is at 0x03C and mask 1 is at 0x040. The two lines are independent, and mask bits 31:22 never raise an interrupt.
- R9: Both masks keep and read back all 32 written bits.
- R10: A read of word k (0 to 7) in the range 0xFE0–0xFFC returns the identification byte from the list 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended to 32 bits.
- R11: A read of any other offset returns zero and changes no state. This includes the clear register and unaligned addresses. A write to the status offset (0x034) also changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_set | input | 11 | Per-bit set pulses for the sticky status bits 10:0 |
| live_flags | input | 11 | Live FIFO/activity state mapped onto status bits 21:11 |
| irq_out | output | 2 | Level interrupts, one per mask register |

## Verification
Register writes, set pulses and clear writes act on the next rising edge. The new value is therefore visible on `bus_rdata` and `irq_out` one clock after the stimulus is presented. Live flags also appear one clock after they change, because they are sampled into a register.

Reads are combinational and take no cycles. The bench therefore drives inputs on the falling edge and releases them on the next falling edge. It samples results a short delay after that second falling edge, so every registered result is observed exactly one rising edge after its cause.

// File: rtl/sdhc_stat_pkg.sv
`timescale 1ns/1ps
// Package: register offsets, status bit layout and identification bytes
// for the SD/MMC host status unit. Offsets are byte addresses within a
// 4 KiB window; all accesses are assumed word aligned.
package sdhc_stat_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int STICKY_W = 11;
    localparam int LIVE_W   = 11;
    localparam int STAT_W   = STICKY_W + LIVE_W;
    localparam int RSVD_BIT = 9;

    localparam logic [ADDR_W-1:0] OFS_PWR   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CLK   = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h038;
    localparam logic [ADDR_W-1:0] OFS_MASK0 = 12'h03C;
    localparam logic [ADDR_W-1:0] OFS_IDBASE = 12'hFE0;

    // Identification byte for word k of the ID window.
    function automatic logic [7:0] id_byte(input logic [2:0] k);
        case (k)
            3'd0:    return 8'h81;
            3'd1:    return 8'h11;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/sdhc_stat_core.sv
`timescale 1ns/1ps
// Module: sdhc_stat_core
// Holds the sticky event bits and samples the live flag bits into one
// status word. Sticky bits are set by pulses and cleared by a masked
// clear strobe; a set in the same cycle as a clear wins. The reserved
// bit is forced to zero. Assumes set pulses are synchronous to clk.
module sdhc_stat_core #(
    parameter int STICKY_W = 11,
    parameter int LIVE_W   = 11,
    parameter int RSVD_BIT = 9,
    localparam int STAT_W  = STICKY_W + LIVE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STICKY_W-1:0] set_pulse,
    input  logic                clr_we,
    input  logic [STICKY_W-1:0] clr_val,
    input  logic [LIVE_W-1:0]   live_in,
    output logic [STAT_W-1:0]   status
);

    localparam logic [STICKY_W-1:0] KEEP = ~(STICKY_W'(1) << RSVD_BIT);

    logic [STICKY_W-1:0] sticky_q;
    logic [STICKY_W-1:0] sticky_d;
    logic [LIVE_W-1:0]   live_q;

    // Next sticky value: clear first, then apply sets so sets dominate.
    always_comb begin
        sticky_d = sticky_q;
        if (clr_we) begin
            sticky_d = sticky_d & ~clr_val;
        end
        sticky_d = (sticky_d | set_pulse) & KEEP;
    end

    // Register sticky bits and sample live flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
            live_q   <= '0;
        end else begin
            sticky_q <= sticky_d;
            live_q   <= live_in;
        end
    end

    assign status = {live_q, sticky_q};

endmodule

// File: rtl/sdhc_irq_mask.sv
`timescale 1ns/1ps
// Module: sdhc_irq_mask
// One mask register and its level interrupt. The full mask word is kept
// for read-back; only the bits that overlap the status word can raise
// the interrupt. Assumes the write strobe lasts one cycle.
module sdhc_irq_mask #(
    parameter int DATA_W = 32,
    parameter int STAT_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STAT_W-1:0] status,
    output logic [DATA_W-1:0] mask_q,
    output logic              irq
);

    // Hold the mask word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (we) begin
            mask_q <= wdata;
        end
    end

    // Level interrupt from the overlap of status and mask.
    always_comb begin
        irq = |(status & mask_q[STAT_W-1:0]);
    end

endmodule

// File: rtl/sdhc_reg_decode.sv
`timescale 1ns/1ps
// Module: sdhc_reg_decode
// Address decode for the register port: write strobes for clear and
// mask registers, the 8-bit power and clock registers, and the
// combinational read multiplexer including the ID window. Unaligned or
// unmapped addresses read zero and strobe nothing.
module sdhc_reg_decode
    import sdhc_stat_pkg::*;
#(
    parameter int NUM_IRQ = 2,
    parameter int STAT_W  = 22,
    localparam int MASK_FW = NUM_IRQ * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         wbyte,
    input  logic [STAT_W-1:0]  status,
    input  logic [MASK_FW-1:0] mask_flat,
    output logic               clr_we,
    output logic [NUM_IRQ-1:0] mask_we,
    output logic [DATA_W-1:0]  rdata
);

    logic       aligned;
    logic [7:0] pwr_q;
    logic [7:0] clk_q;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign clr_we  = bus_we && aligned && (bus_addr == OFS_CLR);

    // One write strobe per mask register at consecutive word offsets.
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mwe
        assign mask_we[i] = bus_we && aligned &&
                            (bus_addr == OFS_MASK0 + ADDR_W'(4 * i));
    end

    // Power and clock registers, low byte only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= '0;
            clk_q <= '0;
        end else if (bus_we && aligned) begin
            if (bus_addr == OFS_PWR) pwr_q <= wbyte;
            if (bus_addr == OFS_CLK) clk_q <= wbyte;
        end
    end

    // Read multiplexer; anything unmapped reads zero.
    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (bus_addr >= OFS_IDBASE) begin
                rdata = DATA_W'(id_byte(bus_addr[4:2]));
            end else if (bus_addr == OFS_PWR) begin
                rdata = DATA_W'(pwr_q);
            end else if (bus_addr == OFS_CLK) begin
                rdata = DATA_W'(clk_q);
            end else if (bus_addr == OFS_STAT) begin
                rdata = DATA_W'(status);
            end else begin
                for (int i = 0; i < NUM_IRQ; i++) begin
                    if (bus_addr == OFS_MASK0 + ADDR_W'(4 * i)) begin
                        rdata = mask_flat[i*DATA_W +: DATA_W];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sdhc_stat_irq.sv
`timescale 1ns/1ps
// Module: sdhc_stat_irq (top)
// Status and dual interrupt unit of an SD/MMC host. Connects the status
// core, one mask/interrupt slice per interrupt line and the register
// decoder. Assumes a single-cycle, word-aligned register port.
module sdhc_stat_irq
    import sdhc_stat_pkg::*;
#(
    parameter int NUM_IRQ = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [STICKY_W-1:0] evt_set,
    input  logic [LIVE_W-1:0]   live_flags,
    output logic [NUM_IRQ-1:0]  irq_out
);

    logic [STAT_W-1:0]         status_w;
    logic                      clr_we;
    logic [NUM_IRQ-1:0]        mask_we;
    logic [NUM_IRQ*DATA_W-1:0] mask_flat;

    sdhc_stat_core #(
        .STICKY_W (STICKY_W),
        .LIVE_W   (LIVE_W),
        .RSVD_BIT (RSVD_BIT)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (evt_set),
        .clr_we    (clr_we),
        .clr_val   (bus_wdata[STICKY_W-1:0]),
        .live_in   (live_flags),
        .status    (status_w)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        sdhc_irq_mask #(
            .DATA_W (DATA_W),
            .STAT_W (STAT_W)
        ) u_mask (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (mask_we[i]),
            .wdata  (bus_wdata),
            .status (status_w),
            .mask_q (mask_flat[i*DATA_W +: DATA_W]),
            .irq    (irq_out[i])
        );
    end

    sdhc_reg_decode #(
        .NUM_IRQ (NUM_IRQ),
        .STAT_W  (STAT_W)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .wbyte     (bus_wdata[7:0]),
        .status    (status_w),
        .mask_flat (mask_flat),
        .clr_we    (clr_we),
        .mask_we   (mask_we),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/sdhc_stat_irq_chk.sv
`timescale 1ns/1ps
// Module: sdhc_stat_irq_chk
// Temporal checks on the status unit, bound into the top module.
module sdhc_stat_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [10:0] evt_set,
    input logic [10:0] live_flags,
    input logic [21:0] status,
    input logic [1:0]  irq_out
);

    logic clr_now;
    assign clr_now = bus_we && (bus_addr == 12'h038);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        ((status[10:0] & $past(evt_set & 11'h5FF)) == $past(evt_set & 11'h5FF)));

    // R5
    clear_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr_now)) |->
        ((status[10:0] & $past(bus_wdata[10:0] & ~evt_set)) == 11'd0));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr_now)) |->
        ((status[10:0] & $past(status[10:0])) == $past(status[10:0])));

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[9] == 1'b0);

    // R7
    live_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (status[21:11] == $past(live_flags)));

    // R8
    quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 22'd0) |-> (irq_out == 2'b00));

endmodule

bind sdhc_stat_irq sdhc_stat_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .evt_set    (evt_set),
    .live_flags (live_flags),
    .status     (status_w),
    .irq_out    (irq_out)
);

// File: tb/sim_sdhc_stat_irq.sv
`timescale 1ns/1ps
// Bench: sweeps over sticky bits, mask bits and the ID window with
// expected values computed from the requirements.
module sim_sdhc_stat_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [10:0] evt_set = '0;
    logic [10:0] live_flags = '0;
    logic [1:0]  irq_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sdhc_stat_irq u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
        .live_flags(live_flags), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FIL_%s FAIL got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        #0.5;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [10:0] s);
        @(negedge clk);
        evt_set = s;
        @(negedge clk);
        evt_set = '0;
        #0.5;
    endtask

    task automatic finish_run;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [21:0] exp_s;
        logic [10:0] live_e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #0.5;

        // R1 reset values
        rd(12'h000, v); check("R1", v, 0);
        rd(12'h004, v); check("R1", v, 0);
        rd(12'h034, v); check("R1", v, 0);
        rd(12'h03C, v); check("R1", v, 0);
        rd(12'h040, v); check("R1", v, 0);
        check("R1", {30'd0, irq_out}, 0);

        // R2 power and clock keep low byte
        wr(12'h000, 32'h1234_56A5); rd(12'h000, v); check("R2", v, 32'hA5);
        wr(12'h004, 32'hFFFF_FF3C); rd(12'h004, v); check("R2", v, 32'h3C);

        // R10 ID window
        for (int k = 0; k < 8; k++) begin
            logic [7:0] idv;
            case (k)
                0: idv = 8'h81; 1: idv = 8'h11; 2: idv = 8'h04; 3: idv = 8'h00;
                4: idv = 8'h0D; 5: idv = 8'hF0; 6: idv = 8'h05; default: idv = 8'hB1;
            endcase
            rd(12'hFE0 + 12'(4 * k), v); check("R10", v, {24'd0, idv});
        end

        // R9 mask read-back of all bits
        wr(12'h03C, 32'hDEAD_BEEF); rd(12'h03C, v); check("R9", v, 32'hDEAD_BEEF);
        wr(12'h040, 32'hC001_D00D); rd(12'h040, v); check("R9", v, 32'hC001_D00D);
        wr(12'h03C, 0); wr(12'h040, 0);

        // R3/R4 sweep each sticky bit, accumulating
        exp_s = '0;
        for (int b = 0; b < 11; b++) begin
            pulse(11'(1) << b);
            if (b != 9) exp_s[b] = 1'b1;
            rd(12'h034, v);
            check(b == 9 ? "R4" : "R3", v, {10'd0, exp_s});
        end

        // R7 live flags appear after one sampling edge
        live_e = 11'h5A5;
        @(negedge clk); live_flags = live_e;
        @(negedge clk); #0.5;
        exp_s[21:11] = live_e;
        rd(12'h034, v); check("R7", v, {10'd0, exp_s});

        // R11 write to status offset changes nothing; unmapped reads zero
        wr(12'h034, 32'hFFFF_FFFF); rd(12'h034, v); check("R11", v, {10'd0, exp_s});
        rd(12'h008, v); check("R11", v, 0);
        rd(12'h038, v); check("R11", v, 0);
        rd(12'h044, v); check("R11", v, 0);
        rd(12'hFDC, v); check("R11", v, 0);
        rd(12'h035, v); check("R11", v, 0);
        rd(12'h034, v); check("R11", v, {10'd0, exp_s});

        // R8 mask sweep: mask0 single bit, mask1 all other status bits
        for (int b = 0; b < 22; b++) begin
            logic [21:0] m1;
            m1 = ~(22'(1) << b);
            wr(12'h03C, 32'(1) << b);
            wr(12'h040, {10'd0, m1});
            check("R8", {31'd0, irq_out[0]}, {31'd0, exp_s[b]});
            check("R8", {31'd0, irq_out[1]}, {31'd0, |(exp_s & m1)});
        end
        // R8 upper mask bits never interrupt
        wr(12'h03C, 32'hFFC0_0000); wr(12'h040, 32'hFFC0_0000);
        check("R8", {30'd0, irq_out}, 0);

        // R5 clear all with upper bits set: live bits stay
        wr(12'h038, 32'hFFFF_FFFF);
        exp_s[10:0] = '0;
        rd(12'h034, v); check("R5", v, {10'd0, exp_s});

        // R5 partial clear
        pulse(11'h4FF);
        wr(12'h038, 32'h0000_0041);
        rd(12'h034, v); check("R5", v, {10'd0, exp_s[21:11], 11'h4BE});

        // R6 set and clear together on bit 0 and bit 3
        wr(12'h038, 32'h7FF);
        pulse(11'h001);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 12'h038; bus_wdata = 32'h0000_0009; evt_set = 11'h008;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; evt_set = '0;
        #0.5;
        rd(12'h034, v); check("R6", v, {10'd0, exp_s[21:11], 11'h008});

        // R8 irq follows status after clear with mask on bit 3
        wr(12'h03C, 32'h0000_0008); check("R8", {31'd0, irq_out[0]}, 1);
        wr(12'h038, 32'h0000_0008); check("R8", {31'd0, irq_out[0]}, 0);

        finish_run();
    end

endmodule